// File: doc/BRIEF.md
# Ping-Pong Clock-Domain Gain Buffer

This block carries 16-bit gain results from a fast acquisition clock domain to a slower 8-bit processor bus. It has two storage banks that take turns. The acquisition side fills one bank while the processor drains the other. A bank moves to the processor side when it reaches its capacity or when the acquisition logic signals the end of a sweep. From then on the acquisition side cannot write into it until the processor hands it back. The hand-over and the hand-back each cross the clock boundary as a per-bank toggle that passes through a two-flop synchronizer.

The processor sees four byte registers on a simple bus made of an enable, a write flag, an address and data. A status register shows whether a bank is waiting to be read, which bank that is, and a sticky overrun flag. Writes to the status address carry two commands: one returns the bank that is being read, and one clears the overrun flag. The count register gives the index of the last entry in the bank that is being read. The entry under the read pointer shows up as two data bytes, and reading the high byte moves the pointer on. The processor clock is expected to come from the acquisition clock divided by two, but the two domains are treated as fully asynchronous.

Top module: `gain_pingpong_bridge`

## Requirements
- R1: After reset the status register (address 0x00) reads 0x00: bit0 (bank ready) is 0, bit1 (bank id) is 0 and bit2 (overrun) is 0. The count register (address 0x01) reads 0 whenever no bank is ready.
- R2: Gain words are written to consecutive entries of the bank being filled. When DEPTH words are stored, the bank moves to the reader. Status bit0 then reads 1 and bit1 gives that bank's id, with the first bank filled after reset being bank 0.
- R3: A `sweep_done` pulse moves the bank being filled to the reader if it holds at least one word. The count register (address 0x01) reads the number of stored entries minus one. A `sweep_done` pulse on an empty bank is ignored.
- R4: Address 0x02 reads the low byte and address 0x03 reads the high byte of the entry under the read pointer. Only a read of 0x03 while a bank is ready moves the pointer on. Entries come out in the order they were written.
- R5: While the reader holds one bank, new words go into the other bank, and the two banks reach the reader in alternating order.
- R6: A processor write to address 0x00 with data bit0 set returns the current bank. The reader then moves on to the other bank id and its pointer goes back to 0. This command is ignored when no bank is ready.
- R7: A gain word that arrives while the reader holds both banks is dropped. It sets the sticky overrun flag (status bit2) and does not change any stored data or count.
- R8: A processor write to address 0x00 with data bit1 set clears the overrun flag.
- R9: A bank that has been returned can be filled again and is handed to the reader again in the normal order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acq_clk | input | 1 | Acquisition domain clock |
| acq_rst_n | input | 1 | Synchronous active-low reset, acquisition domain |
| gain_valid | input | 1 | A gain word is present this cycle |
| gain_data | input | 2*BUS_W | Gain word |
| sweep_done | input | 1 | End of sweep: move the partly filled bank to the reader |
| cpu_clk | input | 1 | Processor bus clock |
| cpu_rst_n | input | 1 | Synchronous active-low reset, processor domain |
| cpu_en | input | 1 | Bus access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Register address |
| cpu_wdata | input | BUS_W | Write data |
| cpu_rdata | output | BUS_W | Read data, registered, valid the cycle after a read |

## Verification
The bench runs a small bank depth and tries every fill level from one entry up to a full bank, so that hand-over by count and hand-over by end of sweep are both covered in both banks. A wrong last-entry index would then give a count that is off by one, and a pointer that moves on a low-byte read would skip entries. It also fills both banks and then pushes one more word. A design that lets this word overwrite the held bank, or that leaves out the overrun flag, gives the wrong count or the wrong status. Release commands sent while no bank is ready and `sweep_done` pulses on an empty bank are applied too. A design that acts on them would switch bank id or hand over a bank with nothing in it.

// File: rtl/gpb_pkg.sv
// Package: register map and bit positions shared by the gain buffer bridge.
// Assumes an 8-bit or wider processor bus; address codes fit in 2 bits.
package gpb_pkg;
    localparam int REG_STATUS = 0;
    localparam int REG_COUNT  = 1;
    localparam int REG_DATA_L = 2;
    localparam int REG_DATA_H = 3;

    localparam int ST_READY = 0;
    localparam int ST_BANK  = 1;
    localparam int ST_OVR   = 2;

    localparam int CMD_RELEASE = 0;
    localparam int CMD_CLR_OVR = 1;
endpackage

// File: rtl/gpb_sync2.sv
// Two-flop synchronizer with an extra stage to detect edges.
// A toggle input becomes a one-cycle pulse, and a level input is passed through.
// Assumes the input changes no faster than once every few destination cycles.
module gpb_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic edge_pulse
);
    logic s1_q, s2_q, s3_q;

    // Capture the asynchronous input and keep one older sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign q          = s2_q;
    assign edge_pulse = s2_q ^ s3_q;
endmodule

// File: rtl/gpb_bank_mem.sv
// Storage for both banks. Writes happen in the acquisition domain and reads are
// combinational. The read side only looks at a bank the writer has handed over,
// so that bank does not change while it is read.
module gpb_bank_mem #(
    parameter int DEPTH  = 256,
    parameter int WORD_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [PTR_W:0]    waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PTR_W:0]    raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem_q [2*DEPTH];

    // Store one gain word per write strobe.
    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/gpb_acq_ctrl.sv
// Acquisition-side controller. It chooses the bank to fill and advances the
// write pointer. It hands a bank over when the bank is full or at end of sweep,
// and frees a bank when the reader returns it. It drops words while the reader
// holds both banks and keeps the sticky overrun flag. DEPTH must be a power of two.
module gpb_acq_ctrl #(
    parameter int DEPTH = 256,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  gain_valid,
    input  logic                  sweep_done,
    input  logic [1:0]            rel_pulse,
    input  logic                  clr_pulse,
    output logic                  mem_we,
    output logic [PTR_W:0]        mem_waddr,
    output logic [1:0]            full_tgl,
    output logic                  ovr_flag,
    output logic [1:0][PTR_W-1:0] last_idx
);
    logic                  wr_bank_q;
    logic [PTR_W-1:0]      wr_ptr_q;
    logic [1:0]            owned_q;
    logic [1:0]            full_tgl_q;
    logic                  ovr_q;
    logic [1:0][PTR_W-1:0] last_q;

    logic accept, drop, fill_end, has_data, hand;
    logic [PTR_W-1:0] final_idx;

    // Decide what to do with this cycle's word and whether to hand over.
    always_comb begin
        accept    = gain_valid && !owned_q[wr_bank_q];
        drop      = gain_valid &&  owned_q[wr_bank_q];
        fill_end  = accept && (wr_ptr_q == PTR_W'(DEPTH - 1));
        has_data  = accept || (wr_ptr_q != '0);
        hand      = !owned_q[wr_bank_q] && (fill_end || (sweep_done && has_data));
        final_idx = accept ? wr_ptr_q : wr_ptr_q - PTR_W'(1);
    end

    // Write pointer and bank selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bank_q <= 1'b0;
            wr_ptr_q  <= '0;
        end else if (hand) begin
            wr_bank_q <= ~wr_bank_q;
            wr_ptr_q  <= '0;
        end else if (accept) begin
            wr_ptr_q  <= wr_ptr_q + PTR_W'(1);
        end
    end

    // Per-bank ownership, hand-over toggle and last-entry index.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                owned_q[b]    <= 1'b0;
                full_tgl_q[b] <= 1'b0;
                last_q[b]     <= '0;
            end else if (hand && (wr_bank_q == 1'(b))) begin
                owned_q[b]    <= 1'b1;
                full_tgl_q[b] <= ~full_tgl_q[b];
                last_q[b]     <= final_idx;
            end else if (rel_pulse[b]) begin
                owned_q[b]    <= 1'b0;
            end
        end

        // R2: a bank becomes owned only together with its hand-over toggle
        a_r2_handover_toggles: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(owned_q[b]) |-> (full_tgl_q[b] != $past(full_tgl_q[b])));
        // R9: a returned bank is writable on the next cycle
        a_r9_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
            rel_pulse[b] |=> !owned_q[b]);
    end

    // Sticky overrun flag: set by a dropped word, cleared by the reader's command.
    always_ff @(posedge clk) begin
        if (!rst_n)         ovr_q <= 1'b0;
        else if (drop)      ovr_q <= 1'b1;
        else if (clr_pulse) ovr_q <= 1'b0;
    end

    // R7: a dropped word always leaves the overrun flag set
    a_r7_drop_sets_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovr_q);
    // R7: nothing is written while the reader holds both banks
    a_r7_no_write_both_owned: assert property (@(posedge clk) disable iff (!rst_n)
        (owned_q == 2'b11) |-> !mem_we);

    assign mem_we    = accept;
    assign mem_waddr = {wr_bank_q, wr_ptr_q};
    assign full_tgl  = full_tgl_q;
    assign ovr_flag  = ovr_q;
    assign last_idx  = last_q;
endmodule

// File: rtl/gpb_cpu_port.sv
// Processor-side register port. It tracks which banks have been handed over,
// which bank is being read and the read pointer. It decodes the status, count
// and data registers and raises the return and clear-overrun toggles.
module gpb_cpu_port #(
    parameter int DEPTH  = 256,
    parameter int BUS_W  = 8,
    parameter int ADDR_W = 8,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int GAIN_W = 2 * BUS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BUS_W-1:0]      wdata,
    output logic [BUS_W-1:0]      rdata,
    input  logic [1:0]            full_pulse,
    input  logic                  ovr_level,
    input  logic [1:0][PTR_W-1:0] last_idx,
    input  logic [GAIN_W-1:0]     rd_word,
    output logic [PTR_W:0]        rd_addr,
    output logic [1:0]            rel_tgl,
    output logic                  clr_tgl
);
    import gpb_pkg::*;

    logic [1:0]       pending_q;
    logic             cur_bank_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [1:0]       rel_tgl_q;
    logic             clr_tgl_q;
    logic [BUS_W-1:0] rdata_q;

    logic ready, is_rd, is_wr, sel_status, sel_count, sel_lo, sel_hi;
    logic release_cmd, clear_cmd, advance;
    logic [BUS_W-1:0] status_byte, count_byte, read_mux;

    // Decode the bus access and build the read value.
    always_comb begin
        ready       = pending_q[cur_bank_q];
        is_rd       = en && !wr;
        is_wr       = en &&  wr;
        sel_status  = (addr == ADDR_W'(REG_STATUS));
        sel_count   = (addr == ADDR_W'(REG_COUNT));
        sel_lo      = (addr == ADDR_W'(REG_DATA_L));
        sel_hi      = (addr == ADDR_W'(REG_DATA_H));
        release_cmd = is_wr && sel_status && wdata[CMD_RELEASE] && ready;
        clear_cmd   = is_wr && sel_status && wdata[CMD_CLR_OVR];
        advance     = is_rd && sel_hi && ready;
        status_byte = '0;
        status_byte[ST_READY] = ready;
        status_byte[ST_BANK]  = cur_bank_q;
        status_byte[ST_OVR]   = ovr_level;
        count_byte  = ready ? BUS_W'(last_idx[cur_bank_q]) : '0;
        if (sel_status)     read_mux = status_byte;
        else if (sel_count) read_mux = count_byte;
        else if (sel_lo)    read_mux = rd_word[BUS_W-1:0];
        else if (sel_hi)    read_mux = rd_word[GAIN_W-1:BUS_W];
        else                read_mux = '0;
    end

    // Banks waiting for the reader: set on hand-over, cleared on return.
    for (genvar b = 0; b < 2; b++) begin : g_pend
        always_ff @(posedge clk) begin
            if (!rst_n)                                      pending_q[b] <= 1'b0;
            else if (full_pulse[b])                          pending_q[b] <= 1'b1;
            else if (release_cmd && (cur_bank_q == 1'(b)))   pending_q[b] <= 1'b0;
        end
    end

    // Current bank, read pointer and return toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_bank_q <= 1'b0;
            rd_ptr_q   <= '0;
            rel_tgl_q  <= '0;
        end else if (release_cmd) begin
            cur_bank_q            <= ~cur_bank_q;
            rd_ptr_q              <= '0;
            rel_tgl_q[cur_bank_q] <= ~rel_tgl_q[cur_bank_q];
        end else if (advance) begin
            rd_ptr_q <= rd_ptr_q + PTR_W'(1);
        end
    end

    // Clear-overrun toggle and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_tgl_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            if (clear_cmd) clr_tgl_q <= ~clr_tgl_q;
            if (is_rd)     rdata_q   <= read_mux;
        end
    end

    // R4: the pointer moves only on a high-byte read or a bank return
    a_r4_ptr_moves_on_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr_q != $past(rd_ptr_q)) |-> ($past(advance) || $past(release_cmd)));
    // R6: the bank id changes only through an accepted return command
    a_r6_bank_switch_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bank_q != $past(cur_bank_q)) |-> $past(release_cmd));
    // R6: an accepted return always moves to the other bank
    a_r6_release_moves_on: assert property (@(posedge clk) disable iff (!rst_n)
        release_cmd |=> (cur_bank_q != $past(cur_bank_q)));

    assign rdata   = rdata_q;
    assign rd_addr = {cur_bank_q, rd_ptr_q};
    assign rel_tgl = rel_tgl_q;
    assign clr_tgl = clr_tgl_q;
endmodule

// File: rtl/gain_pingpong_bridge.sv
// Top level: two-bank gain buffer crossing from the acquisition clock to an
// 8-bit processor bus. Bank hand-over, bank return, overrun clear and the
// overrun level each cross through a synchronizer. The count values need no
// synchronizer because they are stable while a bank is held by the reader.
module gain_pingpong_bridge #(
    parameter int DEPTH  = 256,
    parameter int BUS_W  = 8,
    parameter int ADDR_W = 8,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int GAIN_W = 2 * BUS_W
) (
    input  logic              acq_clk,
    input  logic              acq_rst_n,
    input  logic              gain_valid,
    input  logic [GAIN_W-1:0] gain_data,
    input  logic              sweep_done,
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic              cpu_en,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BUS_W-1:0]  cpu_wdata,
    output logic [BUS_W-1:0]  cpu_rdata
);
    logic                  mem_we;
    logic [PTR_W:0]        mem_waddr, rd_addr;
    logic [GAIN_W-1:0]     rd_word;
    logic [1:0]            full_tgl, full_pulse, rel_tgl, rel_pulse;
    logic [1:0]            full_lvl_unused, rel_lvl_unused;
    logic                  clr_tgl, clr_pulse, clr_lvl_unused;
    logic                  ovr_flag, ovr_level, ovr_edge_unused;
    logic [1:0][PTR_W-1:0] last_idx;

    gpb_acq_ctrl #(.DEPTH(DEPTH)) u_acq (
        .clk(acq_clk), .rst_n(acq_rst_n), .gain_valid(gain_valid),
        .sweep_done(sweep_done), .rel_pulse(rel_pulse), .clr_pulse(clr_pulse),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .full_tgl(full_tgl),
        .ovr_flag(ovr_flag), .last_idx(last_idx)
    );

    gpb_bank_mem #(.DEPTH(DEPTH), .WORD_W(GAIN_W)) u_mem (
        .wclk(acq_clk), .we(mem_we), .waddr(mem_waddr), .wdata(gain_data),
        .raddr(rd_addr), .rdata(rd_word)
    );

    // Per-bank synchronizers in both directions.
    for (genvar b = 0; b < 2; b++) begin : g_xing
        gpb_sync2 u_full_sync (
            .clk(cpu_clk), .rst_n(cpu_rst_n), .d(full_tgl[b]),
            .q(full_lvl_unused[b]), .edge_pulse(full_pulse[b])
        );
        gpb_sync2 u_rel_sync (
            .clk(acq_clk), .rst_n(acq_rst_n), .d(rel_tgl[b]),
            .q(rel_lvl_unused[b]), .edge_pulse(rel_pulse[b])
        );
    end

    gpb_sync2 u_clr_sync (
        .clk(acq_clk), .rst_n(acq_rst_n), .d(clr_tgl),
        .q(clr_lvl_unused), .edge_pulse(clr_pulse)
    );

    gpb_sync2 u_ovr_sync (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .d(ovr_flag),
        .q(ovr_level), .edge_pulse(ovr_edge_unused)
    );

    gpb_cpu_port #(.DEPTH(DEPTH), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_cpu (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .en(cpu_en), .wr(cpu_wr),
        .addr(cpu_addr), .wdata(cpu_wdata), .rdata(cpu_rdata),
        .full_pulse(full_pulse), .ovr_level(ovr_level), .last_idx(last_idx),
        .rd_word(rd_word), .rd_addr(rd_addr), .rel_tgl(rel_tgl), .clr_tgl(clr_tgl)
    );
endmodule

// File: tb/tb_gain_pingpong_bridge.sv
module tb_gain_pingpong_bridge;
    localparam int DEPTH = 8;

    logic        acq_clk = 1'b0, cpu_clk = 1'b0;
    logic        acq_rst_n = 1'b0, cpu_rst_n = 1'b0;
    logic        gain_valid = 1'b0, sweep_done = 1'b0;
    logic [15:0] gain_data = '0;
    logic        cpu_en = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_addr = '0, cpu_wdata = '0;
    logic [7:0]  cpu_rdata;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 acq_clk = ~acq_clk;
    always #4 cpu_clk = ~cpu_clk;

    gain_pingpong_bridge #(.DEPTH(DEPTH)) dut (
        .acq_clk(acq_clk), .acq_rst_n(acq_rst_n), .gain_valid(gain_valid),
        .gain_data(gain_data), .sweep_done(sweep_done),
        .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cpu_en(cpu_en), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    function automatic logic [15:0] gen(int s);
        return 16'((s * 40503 + 7) ^ (s << 9));
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic push(logic [15:0] d);
        @(negedge acq_clk);
        gain_valid = 1'b1; gain_data = d;
        @(negedge acq_clk);
        gain_valid = 1'b0;
    endtask

    task automatic sweep_end();
        @(negedge acq_clk);
        sweep_done = 1'b1;
        @(negedge acq_clk);
        sweep_done = 1'b0;
    endtask

    task automatic settle();
        repeat (12) @(posedge cpu_clk);
    endtask

    task automatic bus_wr(logic [7:0] a, logic [7:0] d);
        @(negedge cpu_clk);
        cpu_en = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge cpu_clk);
        cpu_en = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [7:0] v);
        @(negedge cpu_clk);
        cpu_en = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
        @(negedge cpu_clk);
        cpu_en = 1'b0;
        v = cpu_rdata;
    endtask

    task automatic read_bank(string req, int base, int n);
        logic [7:0] lo, hi;
        for (int i = 0; i < n; i++) begin
            bus_rd(8'h02, lo);
            bus_rd(8'h03, hi);
            chk(req, {hi, lo}, gen(base + i));
        end
    endtask

    initial begin
        logic [7:0] v, lo;
        int seq;
        int bank;
        repeat (5) @(negedge cpu_clk);
        acq_rst_n = 1'b1; cpu_rst_n = 1'b1;
        settle();

        // R1: reset state
        bus_rd(8'h00, v); chk("R1 status after reset", v, 8'h00);
        bus_rd(8'h01, v); chk("R1 count when not ready", v, 0);

        // R2: full bank by count goes to reader as bank 0
        for (int i = 0; i < DEPTH; i++) push(gen(i));
        settle();
        bus_rd(8'h00, v); chk("R2 status bank0 ready", v, 8'h01);
        bus_rd(8'h01, v); chk("R3 count of full bank", v, DEPTH - 1);
        // R4: low byte and other registers do not move the pointer
        bus_rd(8'h02, lo); bus_rd(8'h02, lo); bus_rd(8'h00, v); bus_rd(8'h01, v);
        chk("R4 low byte repeat", lo, gen(0) & 16'hFF);
        read_bank("R4 R2 bank0 data", 0, DEPTH);

        // R5: partial sweep into bank 1 while bank 0 is held
        for (int i = 0; i < 3; i++) push(gen(8 + i));
        sweep_end();
        sweep_end(); // R3: empty-bank end of sweep ignored
        settle();
        bus_rd(8'h00, v); chk("R5 still reading bank0", v, 8'h01);

        // R7: both held, word dropped
        push(gen(99));
        settle();
        bus_rd(8'h00, v); chk("R7 overrun set", v, 8'h05);

        // R6: return bank 0, reader moves to bank 1
        bus_wr(8'h00, 8'h01);
        settle();
        bus_rd(8'h00, v); chk("R6 R5 bank1 ready", v, 8'h07);
        bus_rd(8'h01, v); chk("R3 R7 count of partial bank", v, 2);
        read_bank("R5 bank1 data", 8, 3);

        // R8: clear overrun
        bus_wr(8'h00, 8'h02);
        settle();
        bus_rd(8'h00, v); chk("R8 overrun cleared", v, 8'h03);

        // R9: returned bank 0 refilled
        for (int i = 0; i < DEPTH; i++) push(gen(12 + i));
        settle();
        bus_rd(8'h00, v); chk("R9 bank1 still current", v, 8'h03);
        bus_wr(8'h00, 8'h01);
        settle();
        bus_rd(8'h00, v); chk("R9 refilled bank0 ready", v, 8'h01);
        bus_rd(8'h01, v); chk("R9 count", v, DEPTH - 1);
        read_bank("R9 refilled data", 12, DEPTH);

        // R6: return bank 0, then a return with nothing ready is ignored
        bus_wr(8'h00, 8'h01);
        settle();
        bus_rd(8'h00, v); chk("R6 bank1 not ready", v, 8'h02);
        bus_wr(8'h00, 8'h01);
        settle();
        bus_rd(8'h00, v); chk("R6 return ignored when idle", v, 8'h02);

        // R3: end of sweep on an empty bank is ignored
        sweep_end();
        settle();
        bus_rd(8'h00, v); chk("R3 empty sweep ignored", v, 8'h02);

        // Sweep every fill level, alternating banks (R2 R3 R4 R5 R9)
        seq = 100;
        bank = 1;
        for (int n = 1; n <= DEPTH; n++) begin
            for (int i = 0; i < n; i++) push(gen(seq + i));
            sweep_end();
            settle();
            bus_rd(8'h00, v); chk("R5 sweep status", v, 1 | (bank << 1));
            bus_rd(8'h01, v); chk("R3 sweep count", v, n - 1);
            read_bank("R4 sweep data", seq, n);
            bus_wr(8'h00, 8'h01);
            seq += n;
            bank ^= 1;
        end
        settle();
        bus_rd(8'h00, v); chk("R6 after sweep", v, bank << 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge acq_clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule